// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, once per clock, whether a new interrupt should be raised toward the processor and which of the eight request lines it belongs to. It takes a raw request vector, a mask vector and an in-service vector, and a 3-bit rotation base. Only unmasked requests are candidates. The line at the base offset has top priority, and priority drops as the offset from the base grows, wrapping modulo the line count. A candidate is raised only when it outranks every line already in service. This keeps nested servicing strictly ordered.

On the primary controller of a cascaded pair, a nesting mode can be enabled. In this mode the in-service bit of the cascade line is left out of the current-priority computation. Further requests arriving through the cascade can then still interrupt. The decision logic is combinational. The result is registered, so every input change appears at the outputs one clock later. The request latch and the command decoding sit outside this block.

The pins are level control and status signals that are sampled every cycle. They carry no data stream, so there is no valid/ready handshake. The result never stalls and is never back-pressured.

Top module: `rot_prio_resolver`

## Requirements
- R1: While reset is asserted and on the first edge after it, irq_valid, cpu_irq and irq_line are all 0.
- R2: A line whose mask bit is 1 is never reported, whatever its request bit is.
- R3: Among candidates (req AND NOT mask), the winner is the one with the smallest offset (line - base) mod 8. With base=0, line 0 beats line 7. With base=7, line 7 beats line 0. With base=1, line 7 (offset 6) beats line 0 (offset 7).
- R4: A winner is reported only if its offset is strictly smaller than the smallest offset of any set in-service bit. An in-service bit at the same line or at a smaller offset blocks it. An empty in-service vector blocks nothing.
- R5: irq_line equals (p + base) mod 8, where p is the winning offset.
- R6: With nest_en=1 on a primary instance (IS_PRIMARY=1), in-service bit 2 is ignored in the current-priority computation. With nest_en=0, it counts like any other bit.
- R7: When no candidate wins, irq_valid is 0 and irq_line is 0.
- R8: cpu_irq always equals irq_valid.
- R9: The outputs after a rising edge reflect the req, mask, isr, base and nest_en values sampled at that edge. A change of base or nest_en in one cycle takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Request vector, bit i = line i |
| mask | input | 8 | Mask vector, 1 disables the line |
| isr | input | 8 | In-service vector |
| base | input | 3 | Rotation base: line with top priority |
| nest_en | input | 1 | Ignore the cascade line's in-service bit |
| irq_valid | output | 1 | Registered: an interrupt should be raised |
| irq_line | output | 3 | Registered index of the winning line |
| cpu_irq | output | 1 | Interrupt request toward the processor |

## Verification
The assertions treat every input as a free level that may change on any cycle. They take for granted only that the inputs are stable around the sampling edge and that the parameters give a power-of-two line count. The checker compares each output with its own registered copy of the inputs from the same edge. The bench drives every input on the falling edge, so each rising edge sees settled values. Random patterns come from a fixed LFSR so that masks, in-service vectors, bases and the nesting mode vary together.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_CASCADE = 2;
endpackage

// File: rtl/rpr_prio_enc.sv
module rpr_prio_enc #(
  parameter int unsigned N  = rpr_pkg::DEF_LINES,
  parameter int unsigned IW = $clog2(N),
  parameter int unsigned PW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [PW-1:0] prio
);
  logic [N-1:0] rot;

  // rot[i] is the line at offset i from the base
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [IW-1:0] k;
      k = IW'(i) + base;
      rot[i] = vec[k];
    end
  end

  always_comb begin
    prio = PW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) prio = PW'(i);
    end
  end
endmodule

// File: rtl/rpr_isr_filter.sv
module rpr_isr_filter #(
  parameter int unsigned N          = rpr_pkg::DEF_LINES,
  parameter int unsigned CASCADE    = rpr_pkg::DEF_CASCADE,
  parameter bit          IS_PRIMARY = 1'b1
) (
  input  logic [N-1:0] isr,
  input  logic         nest_en,
  output logic [N-1:0] isr_eff
);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE;

  generate
    if (IS_PRIMARY) begin : g_primary
      assign isr_eff = nest_en ? (isr & ~CASC_BIT) : isr;
    end else begin : g_secondary
      logic unused_nest;
      assign unused_nest = nest_en;
      assign isr_eff = isr;
    end
  endgenerate
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int unsigned N_LINES    = rpr_pkg::DEF_LINES,
  parameter int unsigned CASCADE    = rpr_pkg::DEF_CASCADE,
  parameter bit          IS_PRIMARY = 1'b1,
  localparam int unsigned IW = $clog2(N_LINES),
  localparam int unsigned PW = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] isr,
  input  logic [IW-1:0]      base,
  input  logic               nest_en,
  output logic               irq_valid,
  output logic [IW-1:0]      irq_line,
  output logic               cpu_irq
);
  logic [N_LINES-1:0] cand;
  logic [N_LINES-1:0] isr_eff;
  logic [PW-1:0]      cand_prio;
  logic [PW-1:0]      cur_prio;
  logic               win;
  logic [IW-1:0]      win_line;

  assign cand = req & ~mask;

  rpr_isr_filter #(.N(N_LINES), .CASCADE(CASCADE), .IS_PRIMARY(IS_PRIMARY)) u_filt (
    .isr(isr), .nest_en(nest_en), .isr_eff(isr_eff)
  );

  rpr_prio_enc #(.N(N_LINES)) u_enc_cand (.vec(cand),    .base(base), .prio(cand_prio));
  rpr_prio_enc #(.N(N_LINES)) u_enc_cur  (.vec(isr_eff), .base(base), .prio(cur_prio));

  // empty candidate set yields N, which can never be below cur_prio (at most N)
  assign win      = cand_prio < cur_prio;
  assign win_line = cand_prio[IW-1:0] + base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_line  <= '0;
    end else begin
      irq_valid <= win;
      irq_line  <= win ? win_line : '0;
    end
  end

  assign cpu_irq = irq_valid;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
  parameter int unsigned N       = 8,
  parameter int unsigned CASCADE = 2,
  localparam int unsigned IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  isr,
  input logic          nest_en,
  input logic          irq_valid,
  input logic [IW-1:0] irq_line,
  input logic          cpu_irq
);
  logic [N-1:0] req_q, mask_q, isr_q;
  logic         nest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0; mask_q <= '0; isr_q <= '0; nest_q <= 1'b0;
    end else begin
      req_q <= req; mask_q <= mask; isr_q <= isr; nest_q <= nest_en;
    end
  end

  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!irq_valid && irq_line == '0);
  end

  a_r8_cpu_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == irq_valid);

  a_r2_never_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !mask_q[irq_line]);

  a_r2_requested: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> req_q[irq_line]);

  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~mask_q) == '0) |-> (!irq_valid && irq_line == '0));

  a_r4_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !(nest_q && irq_line == IW'(CASCADE))) |-> !isr_q[irq_line]);
endmodule

bind rot_prio_resolver rpr_checker #(.N(N_LINES), .CASCADE(CASCADE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .isr(isr),
  .nest_en(nest_en), .irq_valid(irq_valid), .irq_line(irq_line), .cpu_irq(cpu_irq)
);

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, isr = '0;
  logic [2:0] base = '0;
  logic       nest_en = 1'b0;
  logic       irq_valid, cpu_irq;
  logic [2:0] irq_line;

  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rot_prio_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mask(mask), .isr(isr), .base(base),
    .nest_en(nest_en), .irq_valid(irq_valid), .irq_line(irq_line), .cpu_irq(cpu_irq)
  );

  function automatic int offset_of(input logic [7:0] v, input logic [2:0] b);
    for (int p = 0; p < 8; p++) if (v[(p + b) % 8]) return p;
    return 8;
  endfunction

  function automatic logic [3:0] model(input logic [7:0] r, m, s, input logic [2:0] b,
                                       input logic n);
    logic [7:0] s2;
    int pc, ps;
    s2 = s;
    if (n) s2[2] = 1'b0;
    pc = offset_of(r & ~m, b);
    ps = offset_of(s2, b);
    if (pc < ps) return {1'b1, 3'((pc + b) % 8)};
    return 4'b0000;
  endfunction

  task automatic drive(input logic [7:0] r, m, s, input logic [2:0] b, input logic n,
                       input string tag);
    @(negedge clk);
    req = r; mask = m; isr = s; base = b; nest_en = n;
    exp_q.push_back(model(r, m, s, b, n));
    tag_q.push_back(tag);
  endtask

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({irq_valid, irq_line} !== e || cpu_irq !== e[3]) begin
        n_fail++;
        $display("FAIL %s: valid/line/cpu=%b/%0d/%b expected %b/%0d/%b",
                 t, irq_valid, irq_line, cpu_irq, e[3], e[2:0], e[3]);
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    req = 8'hFF;
    #35;
    n_chk++;  // R1 reset state
    if (irq_valid !== 1'b0 || irq_line !== 3'd0 || cpu_irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: valid/line/cpu=%b/%0d/%b expected 0/0/0", irq_valid, irq_line, cpu_irq);
    end
    @(negedge clk);
    req = '0;
    rst_n = 1'b1;

    drive(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, "R7 empty");
    drive(8'h0F, 8'h0F, 8'h00, 3'd0, 1'b0, "R2 all masked");
    drive(8'h06, 8'h02, 8'h00, 3'd0, 1'b0, "R2 mask skips line1");
    drive(8'h81, 8'h00, 8'h00, 3'd0, 1'b0, "R3 base0");
    drive(8'h81, 8'h00, 8'h00, 3'd7, 1'b0, "R3 base7");
    drive(8'h81, 8'h00, 8'h00, 3'd1, 1'b0, "R3 base1");
    drive(8'h08, 8'h00, 8'h00, 3'd5, 1'b0, "R5 base5 line3");
    drive(8'h10, 8'h00, 8'h10, 3'd0, 1'b0, "R4 same line blocks");
    drive(8'h10, 8'h00, 8'h02, 3'd0, 1'b0, "R4 higher isr blocks");
    drive(8'h02, 8'h00, 8'h10, 3'd0, 1'b0, "R4 lower isr allows");
    drive(8'h02, 8'h00, 8'h10, 3'd3, 1'b0, "R4 rotation flips order");
    drive(8'h04, 8'h00, 8'h04, 3'd0, 1'b0, "R6 nest off blocks");
    drive(8'h04, 8'h00, 8'h04, 3'd0, 1'b1, "R6 nest on line2");
    drive(8'h08, 8'h00, 8'h04, 3'd0, 1'b1, "R6 nest on line3");
    drive(8'h08, 8'h00, 8'h04, 3'd0, 1'b0, "R6 nest off line3");
    drive(8'hFF, 8'h00, 8'h00, 3'd2, 1'b0, "R9 base2");
    drive(8'hFF, 8'h00, 8'h00, 3'd6, 1'b0, "R9 base6");
    drive(8'h00, 8'h00, 8'h00, 3'd6, 1'b0, "R7 drop to empty");

    lf = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(lf[7:0], lf[15:8] & lf[23:16], lf[31:24] & lf[11:4], lf[18:16], lf[27],
            "R3 R4 R6 random");
    end
    drive(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, "R8 final");
    @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule